// File: doc/BRIEF.md
# Strobed Parallel Digit Writer for a Segment Display

The block takes one character write at a time from a processor bus and keeps the segment pattern for a row of seven-segment digits. A write presents a digit address, a 4-bit character code and two annunciator bits. An active-low strobe frames the write, and the block captures the write on the strobe's trailing (rising) edge. The strobe is brought into the system clock domain through a flip-flop chain. Once the rising edge is seen, the block latches the inputs and fires an internal write pulse of fixed length. That pulse decodes the code into segment states and loads the addressed digit's 9-bit register.

From the accepted edge, a guard window holds the `busy` output high. A strobe edge that arrives inside this window is dropped, so a write in progress cannot be disturbed. The dropped edge also sets a sticky `err` flag, which only reset clears. A build-time parameter selects the character font. One font is hexadecimal. The other is a decimal font with five symbols and a blank. The stored bits are presented flat, so a display waveform generator placed after this block can use them.

Top module: `seg_strobe_wr`

## Requirements
- R1: While reset is high and after it is released, every bit of `seg_flat` is 0, `busy` is 0 and `err` is 0.
- R2: The block samples `dig_addr`, `char_code` and `ann_in` in the clock edge at which it detects the rising edge of `cs_n`. With the default two-stage synchronizer, this is the third rising clock edge after `cs_n` rises. Changes to these inputs after that edge have no effect on the stored result.
- R3: `busy` goes high at the same clock edge that samples the inputs. It then stays high for exactly `GUARD_CYCLES` clock cycles.
- R4: The addressed digit's register takes its new value one clock edge after the inputs are sampled. No other digit's register changes.
- R5: Digit d occupies `seg_flat[9*d +: 9]`. Within it, bits 0..6 are segments a..g, bit 7 is `ann_in[0]` and bit 8 is `ann_in[1]`. A 1 means lit.
- R6: With `DECODE_MODE` set to hexadecimal, codes 0..F give these glyph values for bits 6..0, written gfedcba: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R7: With `DECODE_MODE` set to the decimal font, codes 0..9 match R6. Codes A..F give 40 (dash), 79 (E), 76 (H), 38 (L), 73 (P) and 00 (blank).
- R8: A rising edge of `cs_n` detected while `busy` is high changes no digit register and sets `err`.
- R9: Once `err` is set, it stays set through later accepted writes until reset.
- R10: The falling edge of `cs_n`, and any time `cs_n` is held low, start no write and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Active-low write strobe; the write takes effect on its rising edge |
| dig_addr | input | ADDR_W | Digit select (3 bits by default) |
| char_code | input | 4 | Character code |
| ann_in | input | 2 | Annunciator controls, 1 = on |
| seg_flat | output | 9*NUM_DIGITS | Stored segment bits of all digits |
| busy | output | 1 | High during the guard window after an accepted strobe |
| err | output | 1 | Sticky flag for a strobe that arrived while busy |

## Verification
The bench drives two copies of the block with the same inputs. One copy uses the hexadecimal font and the other the decimal font, so every code is compared under both fonts. Both copies use a 3-cycle write pulse and a 10-cycle guard window instead of the 300-cycle default. With this short window, the busy length can be counted cycle by cycle. It also lets a second strobe land well inside the guard window, and many random writes fit in a short run. The synchronizer keeps its default depth of two, so the capture edge and the register update edge fall at fixed clock counts after the strobe rises.

// File: rtl/seg_wr_pkg.sv
package seg_wr_pkg;

    typedef enum logic {
        DEC_HEX    = 1'b0,
        DEC_CODE_B = 1'b1
    } dec_mode_e;

    localparam int SEG_BITS   = 9;
    localparam int CODE_BITS  = 4;
    localparam int ANN_BITS   = 2;
    localparam int GLYPH_BITS = 7;

    // One stored digit: glyph[0] is segment a, glyph[6] is segment g
    typedef struct packed {
        logic                  ann_hi;
        logic                  ann_lo;
        logic [GLYPH_BITS-1:0] glyph;
    } digit_seg_t;

    // Character request held from the accepted strobe edge
    typedef struct packed {
        logic [CODE_BITS-1:0] code;
        logic [ANN_BITS-1:0]  ann;
    } char_word_t;

    function automatic digit_seg_t pack_digit(input logic [GLYPH_BITS-1:0] glyph,
                                              input logic [ANN_BITS-1:0]   ann);
        digit_seg_t r;
        r.glyph  = glyph;
        r.ann_lo = ann[0];
        r.ann_hi = ann[1];
        return r;
    endfunction

endpackage

// File: rtl/seg_wr_sync.sv
module seg_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // Idle level of the strobe is high; reset to it so release makes no edge
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/seg_wr_oneshot.sv
module seg_wr_oneshot #(
    parameter int PULSE_CYCLES = 4,
    parameter int GUARD_CYCLES = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic accept,
    output logic overrun,
    output logic fire,
    output logic busy
);
    localparam int CNT_W = $clog2(GUARD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL    = CNT_W'(GUARD_CYCLES);
    localparam logic [CNT_W-1:0] PULSE_FLOOR = CNT_W'(GUARD_CYCLES - PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    assign busy    = (cnt_q != '0);
    assign accept  = trigger & ~busy;
    assign overrun = trigger & busy;
    // The write pulse covers the first PULSE_CYCLES cycles of the window
    assign fire    = (cnt_q > PULSE_FLOOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= LOAD_VAL;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/seg_wr_decode.sv
module seg_wr_decode
    import seg_wr_pkg::*;
#(
    parameter dec_mode_e MODE = DEC_CODE_B
) (
    input  logic [CODE_BITS-1:0] code,
    input  logic [ANN_BITS-1:0]  ann,
    output digit_seg_t           seg
);
    logic [GLYPH_BITS-1:0] hex_glyph;
    logic [GLYPH_BITS-1:0] sym_glyph;
    logic [GLYPH_BITS-1:0] glyph;

    always_comb begin
        case (code)
            4'h0:    hex_glyph = 7'h3F;
            4'h1:    hex_glyph = 7'h06;
            4'h2:    hex_glyph = 7'h5B;
            4'h3:    hex_glyph = 7'h4F;
            4'h4:    hex_glyph = 7'h66;
            4'h5:    hex_glyph = 7'h6D;
            4'h6:    hex_glyph = 7'h7D;
            4'h7:    hex_glyph = 7'h07;
            4'h8:    hex_glyph = 7'h7F;
            4'h9:    hex_glyph = 7'h6F;
            4'hA:    hex_glyph = 7'h77;
            4'hB:    hex_glyph = 7'h7C;
            4'hC:    hex_glyph = 7'h39;
            4'hD:    hex_glyph = 7'h5E;
            4'hE:    hex_glyph = 7'h79;
            default: hex_glyph = 7'h71;
        endcase
    end

    // Symbols of the decimal font above nine; code F is blank
    always_comb begin
        case (code)
            4'hA:    sym_glyph = 7'h40;
            4'hB:    sym_glyph = 7'h79;
            4'hC:    sym_glyph = 7'h76;
            4'hD:    sym_glyph = 7'h38;
            4'hE:    sym_glyph = 7'h73;
            default: sym_glyph = 7'h00;
        endcase
    end

    generate
        if (MODE == DEC_HEX) begin : g_hex
            assign glyph = hex_glyph;
        end else begin : g_dec
            assign glyph = (code < 4'hA) ? hex_glyph : sym_glyph;
        end
    endgenerate

    assign seg = pack_digit(glyph, ann);

endmodule

// File: rtl/seg_wr_bank.sv
module seg_wr_bank
    import seg_wr_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int ADDR_W     = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              waddr,
    input  digit_seg_t                     wdata,
    output logic [NUM_DIGITS-1:0]          sel,
    output logic [NUM_DIGITS*SEG_BITS-1:0] seg_flat
);
    generate
        for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
            digit_seg_t q;

            assign sel[d] = we && (waddr == ADDR_W'(d));

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (sel[d]) begin
                    q <= wdata;
                end
            end

            assign seg_flat[d*SEG_BITS +: SEG_BITS] = q;
        end
    endgenerate

endmodule

// File: rtl/seg_strobe_wr.sv
module seg_strobe_wr
    import seg_wr_pkg::*;
#(
    parameter int        NUM_DIGITS   = 8,
    parameter int        SYNC_STAGES  = 2,
    parameter int        PULSE_CYCLES = 4,
    parameter int        GUARD_CYCLES = 300,
    parameter dec_mode_e DECODE_MODE  = DEC_CODE_B,
    localparam int       ADDR_W       = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cs_n,
    input  logic [ADDR_W-1:0]              dig_addr,
    input  logic [CODE_BITS-1:0]           char_code,
    input  logic [ANN_BITS-1:0]            ann_in,
    output logic [NUM_DIGITS*SEG_BITS-1:0] seg_flat,
    output logic                           busy,
    output logic                           err
);
    logic              edge_seen;
    logic              take;
    logic              overrun;
    logic              wr_fire;
    logic [NUM_DIGITS-1:0] wr_sel;

    logic [ADDR_W-1:0] addr_q;
    char_word_t        word_q;
    digit_seg_t        decoded;
    logic              err_q;

    seg_wr_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cs_n),
        .rise     (edge_seen)
    );

    seg_wr_oneshot #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .GUARD_CYCLES (GUARD_CYCLES)
    ) u_oneshot (
        .clk     (clk),
        .rst     (rst),
        .trigger (edge_seen),
        .accept  (take),
        .overrun (overrun),
        .fire    (wr_fire),
        .busy    (busy)
    );

    // Input capture happens only on an accepted edge
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            word_q <= '0;
        end else if (take) begin
            addr_q      <= dig_addr;
            word_q.code <= char_code;
            word_q.ann  <= ann_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (overrun) begin
            err_q <= 1'b1;
        end
    end

    assign err = err_q;

    seg_wr_decode #(
        .MODE (DECODE_MODE)
    ) u_decode (
        .code (word_q.code),
        .ann  (word_q.ann),
        .seg  (decoded)
    );

    seg_wr_bank #(
        .NUM_DIGITS (NUM_DIGITS),
        .ADDR_W     (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_fire),
        .waddr    (addr_q),
        .wdata    (decoded),
        .sel      (wr_sel),
        .seg_flat (seg_flat)
    );

endmodule

// File: rtl/seg_strobe_wr_chk.sv
module seg_strobe_wr_chk #(
    parameter int NUM_DIGITS = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    busy,
    input logic                    err,
    input logic [NUM_DIGITS*9-1:0] seg_flat,
    input logic                    trig,
    input logic                    fire,
    input logic [NUM_DIGITS-1:0]   sel
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (seg_flat == '0 && !busy && !err));

    p_accept_sets_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (trig && !busy) |=> busy);

    p_write_inside_window_r4: assert property (@(posedge clk) disable iff (rst)
        fire |-> busy);

    p_single_digit_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    p_hold_without_write_r4: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(seg_flat));

    p_overlap_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> err);

    p_err_needs_busy_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(busy));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

bind seg_strobe_wr seg_strobe_wr_chk #(
    .NUM_DIGITS (NUM_DIGITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .err      (err),
    .seg_flat (seg_flat),
    .trig     (edge_seen),
    .fire     (wr_fire),
    .sel      (wr_sel)
);

// File: tb/seg_strobe_wr_bench.sv
module seg_strobe_wr_bench;
    import seg_wr_pkg::*;

    localparam int ND  = 8;
    localparam int PUL = 3;
    localparam int GRD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic [2:0] addr = '0;
    logic [3:0] code = '0;
    logic [1:0] ann  = '0;

    logic [ND*9-1:0] seg_b, seg_h;
    logic busy_b, busy_h, err_b, err_h;

    int total = 0;
    int bad   = 0;
    logic [8:0] mb [ND];
    logic [8:0] mh [ND];

    always #5 clk = ~clk;

    seg_strobe_wr #(
        .NUM_DIGITS(ND), .PULSE_CYCLES(PUL), .GUARD_CYCLES(GRD), .DECODE_MODE(DEC_CODE_B)
    ) u_seg_strobe_wr (
        .clk(clk), .rst(rst), .cs_n(cs_n), .dig_addr(addr), .char_code(code),
        .ann_in(ann), .seg_flat(seg_b), .busy(busy_b), .err(err_b)
    );

    seg_strobe_wr #(
        .NUM_DIGITS(ND), .PULSE_CYCLES(PUL), .GUARD_CYCLES(GRD), .DECODE_MODE(DEC_HEX)
    ) u_seg_strobe_wr_hex (
        .clk(clk), .rst(rst), .cs_n(cs_n), .dig_addr(addr), .char_code(code),
        .ann_in(ann), .seg_flat(seg_h), .busy(busy_h), .err(err_h)
    );

    task automatic chk(input string tag, input logic [ND*9-1:0] act, input logic [ND*9-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] font(input bit hex, input logic [3:0] c);
        if (!hex && c >= 4'hA) begin
            case (c)
                4'hA: return 7'h40;
                4'hB: return 7'h79;
                4'hC: return 7'h76;
                4'hD: return 7'h38;
                4'hE: return 7'h73;
                default: return 7'h00;
            endcase
        end
        case (c)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    function automatic logic [ND*9-1:0] flat(input bit hex);
        logic [ND*9-1:0] f;
        for (int d = 0; d < ND; d++) f[d*9 +: 9] = hex ? mh[d] : mb[d];
        return f;
    endfunction

    task automatic clear_model();
        for (int d = 0; d < ND; d++) begin
            mb[d] = '0;
            mh[d] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
        @(negedge clk);
        chk("R1 seg after reset", seg_b | seg_h, '0);
        chk("R1 busy after reset", {busy_b, busy_h}, '0);
        chk("R1 err after reset", {err_b, err_h}, '0);
    endtask

    // One strobe; the rising edge is at the negedge that ends the low phase
    task automatic strobe(input logic [2:0] a, input logic [3:0] c, input logic [1:0] an,
                          input int low_cycles);
        int n;
        @(negedge clk);
        addr = a; code = c; ann = an; cs_n = 1'b0;
        for (int i = 0; i < low_cycles; i++) begin
            @(negedge clk);
            chk("R10 busy while strobe low", busy_b, 1'b0);
            chk("R10 seg while strobe low", seg_b, flat(0));
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk("R3 busy one edge after rise", busy_b, 1'b0);
        @(negedge clk);
        chk("R3 busy two edges after rise", busy_b, 1'b0);
        @(negedge clk);
        chk("R3 busy at capture edge", {busy_b, busy_h}, 2'b11);
        chk("R4 seg unchanged at capture edge", seg_b, flat(0));
        // R2: inputs scrambled after the capture edge must not matter
        addr = 3'($urandom); code = 4'($urandom); ann = 2'($urandom);
        mb[a] = {an, font(0, c)};
        mh[a] = {an, font(1, c)};
        @(negedge clk);
        chk("R4 R7 R2 decimal font digit update", seg_b, flat(0));
        chk("R4 R6 R2 hex font digit update", seg_h, flat(1));
        n = 2;
        for (int k = 0; k < 4 * GRD; k++) begin
            @(negedge clk);
            if (!busy_b) break;
            n++;
        end
        chk("R3 busy window length", 72'(n), 72'(GRD));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        clear_model();
        do_reset();

        // Directed: every code under both fonts, walking the digits
        for (int i = 0; i < 16; i++) strobe(3'(i), 4'(i), 2'(i), 2);

        // R5: field positions of the outer digits
        strobe(3'd7, 4'h8, 2'b10, 1);
        chk("R5 digit 7 field", 72'(seg_b[71:63]), 72'(9'h17F));
        strobe(3'd0, 4'h1, 2'b01, 1);
        chk("R5 digit 0 field", 72'(seg_b[8:0]), 72'(9'h086));

        // R10: long low phase, nothing until the rise
        strobe(3'd4, 4'hF, 2'b00, 20);
        chk("R7 blank code", 72'(seg_b[44:36]), 72'(0));

        // Random writes
        for (int i = 0; i < 40; i++)
            strobe(3'($urandom), 4'($urandom), 2'($urandom), 1 + int'($urandom % 4));
        chk("R9 err clear before overlap", {err_b, err_h}, '0);

        // R8: second strobe inside the guard window
        @(negedge clk);
        addr = 3'd3; code = 4'h5; ann = 2'b01; cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        mb[3] = {2'b01, font(0, 4'h5)};
        mh[3] = {2'b01, font(1, 4'h5)};
        addr = 3'd6; code = 4'h8; ann = 2'b11; cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (GRD + 6) @(negedge clk);
        chk("R8 err set on overlapping strobe", {err_b, err_h}, 2'b11);
        chk("R8 overlapping strobe ignored", seg_b, flat(0));
        chk("R8 overlapping strobe ignored hex", seg_h, flat(1));
        chk("R8 busy released", busy_b, 1'b0);

        // R9: err stays through an accepted write
        strobe(3'd6, 4'h2, 2'b00, 2);
        chk("R9 err sticky", {err_b, err_h}, 2'b11);

        do_reset();
        strobe(3'd2, 4'hC, 2'b11, 1);
        chk("R1 err cleared only by reset", err_b, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule